// File: doc/BRIEF.md
# One-Time-Programmable Security Fuse Controller

This block models a bank of write-once fuse registers that sit behind a serial access port. There are three registers. A 256-bit key word feeds the decryption logic. A 57-bit identifier is fixed at manufacture and can only be read. A 32-bit control word holds the protection settings. Each logical bit is stored in two fuse cells, a primary and a redundant one. A holding flip-flop takes the OR of the two cells while reset is asserted. After reset, every read and every protection decision uses the holding flip-flops.

Software first sets the select input to choose a register. It then pulses a capture input to copy the latched word into a shared shift register. It clocks bits out or in with the shift enable. A write ends with the update strobe, and the shifted word is blown into the fuse cells on the following clock. Fuses can only be set. A cleared bit in a written word changes nothing.

The control word drives several protections. Redundant pairs of control bits block access to the key and to the control word. One bit restricts configuration to streams encrypted with the fuse key. Another bit locks configuration after the first success, and only a full-clear request or a reset releases that lock. Any access that protection refuses raises a sticky violation flag.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Each logical bit reads as programmed when its primary or its redundant cell is programmed. A word written to the key or control register reads back in full after the next reset.
- R2: The select encoding is 0 = key, 1 = identifier, 2 = control, 3 = none. The key is 256 bits and moves bit 255 first. The identifier is 57 bits and moves bit 56 first. The control word is 32 bits and moves bit 0 first. A write to the identifier leaves its value unchanged. Select 3 reads all zeros.
- R3: Programming is one-way. After a write and a reset, a register reads as the OR of its previous contents and the written word.
- R4: While control bit 8 or bit 12 is latched as set, `cntlBlocked` is high, a capture of the control word shifts out all zeros, and writes to the control word are refused.
- R5: While control bit 10 or bit 14 is latched as set, `keyBlocked` is high, a capture of the key shifts out all zeros, and writes to the key are refused.
- R6: While control bit 17 is latched as set, `keyOnly` is high and a configuration request is accepted only when both `cfgEncrypted` and `cfgFuseKey` are high. While bit 17 is clear, any request that is not locked out is accepted.
- R7: While control bit 16 is latched as set, an accepted request sets `cfgLocked`, and later requests are rejected. `fullClear` clears the lock on the next edge, takes priority over a request in the same cycle, and the request in that cycle is still judged against the old lock. Reset also clears the lock.
- R8: Control bits 0–7, 9, 11, 13, 15 and 18–31 are reserved. Writes to them are ignored, and they read back as zero.
- R9: `accessViolation` sets after a refused capture or a refused write. It stays set through later permitted accesses and clears only on reset.
- R10: Every configuration request produces `cfgAck` one clock later. `cfgOk` is high in that same cycle when the request was accepted.
- R11: Protection outputs and read data come from the values latched at reset. A word committed after reset changes neither of them until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low power-up reset; latches the fuse cells |
| regSel | input | 2 | Register select: 0 key, 1 identifier, 2 control, 3 none |
| captureReq | input | 1 | Loads the latched word of the selected register into the shift register |
| shiftEn | input | 1 | Shifts one bit in from serIn and on to serOut |
| serIn | input | 1 | Serial write data |
| updateStrobe | input | 1 | Commits the shifted word to the selected register's fuses one clock later |
| serOut | output | 1 | Serial read data, the next bit in the selected register's order |
| cfgReq | input | 1 | Configuration attempt |
| cfgEncrypted | input | 1 | The attempt carries an encrypted stream |
| cfgFuseKey | input | 1 | The stream uses the fuse key rather than the alternate key source |
| fullClear | input | 1 | Full-clear request that releases the configuration lock |
| cfgAck | output | 1 | Pulse one clock after cfgReq |
| cfgOk | output | 1 | The acknowledged attempt was accepted |
| cfgLocked | output | 1 | Configuration is locked until a full clear or a reset |
| keyOnly | output | 1 | Only fuse-key encrypted streams are allowed |
| keyBlocked | output | 1 | Key reads and writes are blocked |
| cntlBlocked | output | 1 | Control-word reads and writes are blocked |
| accessViolation | output | 1 | Sticky flag for refused accesses |

## Verification
Properties are checked on every cycle. Fuse cells never clear, and a holding bit is set only when one of its cells is set. Reserved control bits never latch. Protection outputs stay unchanged between resets. A blocked capture gives zero serial data and raises the violation flag, and the flag stays set once raised. Each request is acknowledged on the next cycle, and requests under key-only mode or a held lock are rejected. Several behaviours involve a write, a reset and a read-back, so only the bench scenarios can show them. These are the bit orders of the three registers, the OR-accumulation across writes and resets, refused writes to the identifier, and the delay before a new protection bit takes effect. The bench also checks the lock, the full-clear sequence and the key-only decisions against a reference model.

// File: rtl/otp_fuse_pkg.sv
`timescale 1ns/1ps
package otp_fuse_pkg;

  // Control-word bit positions decoded by the protection logic
  localparam int BIT_CNTL_LOCK_A = 8;
  localparam int BIT_KEY_LOCK_A  = 10;
  localparam int BIT_CNTL_LOCK_B = 12;
  localparam int BIT_KEY_LOCK_B  = 14;
  localparam int BIT_CFG_LOCK    = 16;
  localparam int BIT_KEY_ONLY    = 17;

  typedef enum logic [1:0] {
    SEL_KEY  = 2'd0,
    SEL_ID   = 2'd1,
    SEL_CNTL = 2'd2,
    SEL_NONE = 2'd3
  } fuseSel_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;     // load shift register from latched word
    logic zeroFill;    // capture loads zeros instead (blocked read)
    logic shift;       // shift one bit
    logic latchWord;   // hold shifted word for commit
    logic commitKey;   // blow key cells
    logic commitCntl;  // blow control cells
  } dpStrobe_t;

endpackage

// File: rtl/fuse_cell_word.sv
`timescale 1ns/1ps
module fuse_cell_word #(
  parameter int           W        = 32,
  parameter logic [W-1:0] INIT_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         progEn,
  input  logic [W-1:0] progData,
  output logic [W-1:0] holdVal
);

  // Non-volatile cells: no reset, only ever set
  logic [W-1:0] primCell = INIT_VAL;
  logic [W-1:0] redCell  = INIT_VAL;

  always_ff @(posedge clk) begin
    if (progEn) begin
      primCell <= primCell | progData;
      redCell  <= redCell  | progData;
    end
  end

  // Holding flops sample the OR of both cells while reset is applied
  always_ff @(posedge clk) begin
    if (!rstN) holdVal <= primCell | redCell;
  end

endmodule

// File: rtl/fuse_datapath.sv
`timescale 1ns/1ps
module fuse_datapath
  import otp_fuse_pkg::*;
#(
  parameter int                KEY_W     = 256,
  parameter int                ID_W      = 57,
  parameter int                CNTL_W    = 32,
  parameter logic [ID_W-1:0]   ID_VALUE  = '0,
  parameter logic [CNTL_W-1:0] CNTL_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  fuseSel_e          regSel,
  input  logic              serIn,
  input  dpStrobe_t         strobe,
  output logic              serOut,
  output logic [CNTL_W-1:0] cntlHold
);

  localparam int MAX_KI = (KEY_W > ID_W) ? KEY_W : ID_W;
  localparam int SR_W   = (MAX_KI > CNTL_W) ? MAX_KI : CNTL_W;
  localparam logic [SR_W-1:0] ALL_ONES = {SR_W{1'b1}};
  localparam logic [SR_W-1:0] KEY_WMASK  = ALL_ONES >> (SR_W - KEY_W);
  localparam logic [SR_W-1:0] ID_WMASK   = ALL_ONES >> (SR_W - ID_W);
  localparam logic [SR_W-1:0] CNTL_WMASK = ALL_ONES >> (SR_W - CNTL_W);

  logic [KEY_W-1:0]  keyHold;
  logic [ID_W-1:0]   idHold;
  logic [SR_W-1:0]   shiftReg;
  logic [SR_W-1:0]   shiftNext;
  logic [SR_W-1:0]   captureWord;
  logic [SR_W-1:0]   wordReg;

  // Fuse storage, one instance per register
  fuse_cell_word #(.W(KEY_W), .INIT_VAL('0)) u_keyCells (
    .clk      (clk),
    .rstN     (rstN),
    .progEn   (strobe.commitKey),
    .progData (wordReg[KEY_W-1:0]),
    .holdVal  (keyHold)
  );

  fuse_cell_word #(.W(ID_W), .INIT_VAL(ID_VALUE)) u_idCells (
    .clk      (clk),
    .rstN     (rstN),
    .progEn   (1'b0),
    .progData ('0),
    .holdVal  (idHold)
  );

  fuse_cell_word #(.W(CNTL_W), .INIT_VAL('0)) u_cntlCells (
    .clk      (clk),
    .rstN     (rstN),
    .progEn   (strobe.commitCntl),
    .progData (wordReg[CNTL_W-1:0] & CNTL_MASK),
    .holdVal  (cntlHold)
  );

  // Word loaded at capture
  always_comb begin
    captureWord = '0;
    if (!strobe.zeroFill) begin
      unique case (regSel)
        SEL_KEY:  captureWord = SR_W'(keyHold);
        SEL_ID:   captureWord = SR_W'(idHold);
        SEL_CNTL: captureWord = SR_W'(cntlHold);
        default:  captureWord = '0;
      endcase
    end
  end

  // Shift direction and length depend on the selected register
  always_comb begin
    shiftNext = '0;
    unique case (regSel)
      SEL_KEY:  shiftNext = {shiftReg[SR_W-2:0], serIn} & KEY_WMASK;
      SEL_ID:   shiftNext = {shiftReg[SR_W-2:0], serIn} & ID_WMASK;
      SEL_CNTL: begin
        shiftNext = (shiftReg >> 1) & CNTL_WMASK;
        shiftNext[CNTL_W-1] = serIn;
      end
      default:  shiftNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      wordReg  <= '0;
    end else begin
      if (strobe.capture)    shiftReg <= captureWord;
      else if (strobe.shift) shiftReg <= shiftNext;
      if (strobe.latchWord)  wordReg  <= shiftReg;
    end
  end

  always_comb begin
    unique case (regSel)
      SEL_KEY:  serOut = shiftReg[KEY_W-1];
      SEL_ID:   serOut = shiftReg[ID_W-1];
      SEL_CNTL: serOut = shiftReg[0];
      default:  serOut = 1'b0;
    endcase
  end

endmodule

// File: rtl/fuse_control.sv
`timescale 1ns/1ps
module fuse_control
  import otp_fuse_pkg::*;
#(
  parameter int CNTL_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fuseSel_e          regSel,
  input  logic              captureReq,
  input  logic              shiftEn,
  input  logic              updateStrobe,
  input  logic              cfgReq,
  input  logic              cfgEncrypted,
  input  logic              cfgFuseKey,
  input  logic              fullClear,
  input  logic [CNTL_W-1:0] cntlHold,
  output dpStrobe_t         strobe,
  output logic              keyBlocked,
  output logic              cntlBlocked,
  output logic              keyOnly,
  output logic              cfgLocked,
  output logic              cfgAck,
  output logic              cfgOk,
  output logic              accessViolation
);

  logic lockOnCfg;
  logic selBlocked;
  logic cfgAccept;
  logic pendKey;
  logic pendCntl;
  logic pendViol;

  // Protection decode from latched control word (redundant pairs ORed)
  assign cntlBlocked = cntlHold[BIT_CNTL_LOCK_A] | cntlHold[BIT_CNTL_LOCK_B];
  assign keyBlocked  = cntlHold[BIT_KEY_LOCK_A]  | cntlHold[BIT_KEY_LOCK_B];
  assign keyOnly     = cntlHold[BIT_KEY_ONLY];
  assign lockOnCfg   = cntlHold[BIT_CFG_LOCK];

  assign selBlocked = ((regSel == SEL_KEY)  && keyBlocked) ||
                      ((regSel == SEL_CNTL) && cntlBlocked);

  always_comb begin
    strobe            = '0;
    strobe.capture    = captureReq;
    strobe.zeroFill   = selBlocked;
    strobe.shift      = shiftEn & ~captureReq;
    strobe.latchWord  = updateStrobe;
    strobe.commitKey  = pendKey;
    strobe.commitCntl = pendCntl;
  end

  // Commit one clock after the update strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendKey  <= 1'b0;
      pendCntl <= 1'b0;
      pendViol <= 1'b0;
    end else begin
      pendKey  <= updateStrobe && (regSel == SEL_KEY)  && !keyBlocked;
      pendCntl <= updateStrobe && (regSel == SEL_CNTL) && !cntlBlocked;
      pendViol <= updateStrobe && selBlocked;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) accessViolation <= 1'b0;
    else if ((captureReq && selBlocked) || pendViol) accessViolation <= 1'b1;
  end

  // Configuration gate
  assign cfgAccept = !cfgLocked && (!keyOnly || (cfgEncrypted && cfgFuseKey));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAck    <= 1'b0;
      cfgOk     <= 1'b0;
      cfgLocked <= 1'b0;
    end else begin
      cfgAck <= cfgReq;
      cfgOk  <= cfgReq && cfgAccept;
      if (fullClear)                              cfgLocked <= 1'b0;
      else if (cfgReq && cfgAccept && lockOnCfg)  cfgLocked <= 1'b1;
    end
  end

endmodule

// File: rtl/otp_fuse_ctrl.sv
`timescale 1ns/1ps
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int              KEY_W    = 256,
  parameter int              ID_W     = 57,
  parameter int              CNTL_W   = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 57'h1DEADBEEF012345
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       captureReq,
  input  logic       shiftEn,
  input  logic       serIn,
  input  logic       updateStrobe,
  output logic       serOut,
  input  logic       cfgReq,
  input  logic       cfgEncrypted,
  input  logic       cfgFuseKey,
  input  logic       fullClear,
  output logic       cfgAck,
  output logic       cfgOk,
  output logic       cfgLocked,
  output logic       keyOnly,
  output logic       keyBlocked,
  output logic       cntlBlocked,
  output logic       accessViolation
);

  localparam logic [CNTL_W-1:0] CNTL_MASK =
      (CNTL_W'(1) << BIT_CNTL_LOCK_A) | (CNTL_W'(1) << BIT_KEY_LOCK_A) |
      (CNTL_W'(1) << BIT_CNTL_LOCK_B) | (CNTL_W'(1) << BIT_KEY_LOCK_B) |
      (CNTL_W'(1) << BIT_CFG_LOCK)    | (CNTL_W'(1) << BIT_KEY_ONLY);

  fuseSel_e          selEnum;
  dpStrobe_t         strobe;
  logic [CNTL_W-1:0] cntlHold;

  assign selEnum = fuseSel_e'(regSel);

  fuse_control #(.CNTL_W(CNTL_W)) u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .regSel          (selEnum),
    .captureReq      (captureReq),
    .shiftEn         (shiftEn),
    .updateStrobe    (updateStrobe),
    .cfgReq          (cfgReq),
    .cfgEncrypted    (cfgEncrypted),
    .cfgFuseKey      (cfgFuseKey),
    .fullClear       (fullClear),
    .cntlHold        (cntlHold),
    .strobe          (strobe),
    .keyBlocked      (keyBlocked),
    .cntlBlocked     (cntlBlocked),
    .keyOnly         (keyOnly),
    .cfgLocked       (cfgLocked),
    .cfgAck          (cfgAck),
    .cfgOk           (cfgOk),
    .accessViolation (accessViolation)
  );

  fuse_datapath #(
    .KEY_W     (KEY_W),
    .ID_W      (ID_W),
    .CNTL_W    (CNTL_W),
    .ID_VALUE  (ID_VALUE),
    .CNTL_MASK (CNTL_MASK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (selEnum),
    .serIn    (serIn),
    .strobe   (strobe),
    .serOut   (serOut),
    .cntlHold (cntlHold)
  );

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_chk #(
  parameter int CNTL_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regSel,
  input logic              captureReq,
  input logic              cfgReq,
  input logic              cfgEncrypted,
  input logic              cfgFuseKey,
  input logic              fullClear,
  input logic              serOut,
  input logic              cfgAck,
  input logic              cfgOk,
  input logic              cfgLocked,
  input logic              keyOnly,
  input logic              keyBlocked,
  input logic              cntlBlocked,
  input logic              accessViolation,
  input logic [CNTL_W-1:0] cntlHold
);

  localparam logic [CNTL_W-1:0] LIVE_BITS =
      (CNTL_W'(1) << 8) | (CNTL_W'(1) << 10) | (CNTL_W'(1) << 12) |
      (CNTL_W'(1) << 14) | (CNTL_W'(1) << 16) | (CNTL_W'(1) << 17);

  AST_CNTL_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (captureReq && regSel == 2'd2 && cntlBlocked) |=> !serOut); // R4

  AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (captureReq && regSel == 2'd0 && keyBlocked) |=> !serOut); // R5

  AST_KEYONLY_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && keyOnly && !(cfgEncrypted && cfgFuseKey)) |=> !cfgOk); // R6

  AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && cfgLocked) |=> !cfgOk); // R7

  AST_CLEAR_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    fullClear |=> !cfgLocked); // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cntlHold & ~LIVE_BITS) == '0); // R8

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    accessViolation |=> accessViolation); // R9

  AST_VIOL_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (captureReq && ((regSel == 2'd0 && keyBlocked) || (regSel == 2'd2 && cntlBlocked)))
      |=> accessViolation); // R9

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |=> cfgAck); // R10

  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReq |=> (!cfgAck && !cfgOk)); // R10

  AST_PROTECT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($stable(keyBlocked) && $stable(cntlBlocked) && $stable(keyOnly))); // R11

endmodule

module fuse_cell_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] primCell,
  input logic [W-1:0] redCell,
  input logic [W-1:0] holdVal
);

  AST_CELL_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(primCell) & ~primCell) == '0) && (($past(redCell) & ~redCell) == '0)); // R3

  AST_HOLD_FROM_CELLS: assert property (@(posedge clk) disable iff (!rstN)
    (holdVal & ~(primCell | redCell)) == '0); // R1

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.CNTL_W(CNTL_W)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .regSel          (regSel),
  .captureReq      (captureReq),
  .cfgReq          (cfgReq),
  .cfgEncrypted    (cfgEncrypted),
  .cfgFuseKey      (cfgFuseKey),
  .fullClear       (fullClear),
  .serOut          (serOut),
  .cfgAck          (cfgAck),
  .cfgOk           (cfgOk),
  .cfgLocked       (cfgLocked),
  .keyOnly         (keyOnly),
  .keyBlocked      (keyBlocked),
  .cntlBlocked     (cntlBlocked),
  .accessViolation (accessViolation),
  .cntlHold        (cntlHold)
);

bind fuse_cell_word fuse_cell_chk #(.W(W)) u_cellChk (
  .clk      (clk),
  .rstN     (rstN),
  .primCell (primCell),
  .redCell  (redCell),
  .holdVal  (holdVal)
);

// File: tb/tb_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module tb_otp_fuse_ctrl;

  localparam int KEY_W = 256;
  localparam int ID_W  = 57;
  localparam int CW    = 32;
  localparam logic [ID_W-1:0] IDV = 57'h1DEADBEEF012345;
  localparam logic [31:0] LIVE = 32'h0003_5500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic captureReq = 0, shiftEn = 0, serIn = 0, updateStrobe = 0;
  logic cfgReq = 0, cfgEncrypted = 0, cfgFuseKey = 0, fullClear = 0;
  logic serOut, cfgAck, cfgOk, cfgLocked, keyOnly, keyBlocked, cntlBlocked, accessViolation;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;

  // Reference model
  logic [255:0] fuseKeyM = '0, holdKeyM = '0;
  logic [31:0]  fuseCntlM = '0, holdCntlM = '0;
  bit lockedM = 0;

  always #4 clk = ~clk;

  otp_fuse_ctrl dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .captureReq(captureReq),
    .shiftEn(shiftEn), .serIn(serIn), .updateStrobe(updateStrobe), .serOut(serOut),
    .cfgReq(cfgReq), .cfgEncrypted(cfgEncrypted), .cfgFuseKey(cfgFuseKey),
    .fullClear(fullClear), .cfgAck(cfgAck), .cfgOk(cfgOk), .cfgLocked(cfgLocked),
    .keyOnly(keyOnly), .keyBlocked(keyBlocked), .cntlBlocked(cntlBlocked),
    .accessViolation(accessViolation)
  );

  function automatic bit mKeyBlk();  return holdCntlM[10] | holdCntlM[14]; endfunction
  function automatic bit mCntlBlk(); return holdCntlM[8]  | holdCntlM[12]; endfunction
  function automatic bit mCfgOk(bit enc, bit fk);
    return !lockedM && (!holdCntlM[17] || (enc && fk));
  endfunction
  function automatic int widthOf(logic [1:0] s);
    return (s == 2'd0) ? KEY_W : (s == 2'd1) ? ID_W : CW;
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    holdKeyM = fuseKeyM; holdCntlM = fuseCntlM; lockedM = 0;
  endtask

  task automatic readReg(input logic [1:0] s, output logic [255:0] v);
    int w;
    w = widthOf(s);
    v = '0;
    @(negedge clk); regSel = s; captureReq = 1;
    @(negedge clk); captureReq = 0;
    for (int i = 0; i < w; i++) begin
      if (s == 2'd2) v[i] = serOut; else v[w-1-i] = serOut;
      shiftEn = 1;
      @(negedge clk);
      shiftEn = 0;
    end
  endtask

  task automatic writeReg(input logic [1:0] s, input logic [255:0] v);
    int w;
    w = widthOf(s);
    @(negedge clk); regSel = s;
    for (int i = 0; i < w; i++) begin
      serIn = (s == 2'd2) ? v[i] : v[w-1-i];
      shiftEn = 1;
      @(negedge clk);
    end
    shiftEn = 0; updateStrobe = 1;
    @(negedge clk); updateStrobe = 0;
    @(negedge clk); @(negedge clk);
    if (s == 2'd0 && !mKeyBlk())  fuseKeyM  = fuseKeyM | v;
    if (s == 2'd2 && !mCntlBlk()) fuseCntlM = fuseCntlM | (v[31:0] & LIVE);
  endtask

  task automatic cfgTry(bit enc, bit fk, bit fc, string req);
    bit expOk;
    expOk = mCfgOk(enc, fk);
    @(negedge clk); cfgReq = 1; cfgEncrypted = enc; cfgFuseKey = fk; fullClear = fc;
    @(negedge clk); cfgReq = 0; fullClear = 0;
    check(cfgAck == 1'b1, {req, " ack"}, 256'(cfgAck), 256'(1));
    check(cfgOk == expOk, {req, " ok"}, 256'(cfgOk), 256'(expOk));
    lockedM = fc ? 1'b0 : (lockedM | (expOk & holdCntlM[16]));
    check(cfgLocked == lockedM, {req, " lock"}, 256'(cfgLocked), 256'(lockedM));
  endtask

  function automatic logic [255:0] randWide();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic checkFlags(string req);
    check({keyOnly, keyBlocked, cntlBlocked} == {holdCntlM[17], mKeyBlk(), mCntlBlk()},
          req, 256'({keyOnly, keyBlocked, cntlBlocked}),
          256'({holdCntlM[17], mKeyBlk(), mCntlBlk()}));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      testCount++; failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [255:0] v, k1, k2;
    void'($urandom(32'h5EED_0F05));
    doReset();
    // Reset state
    check({cfgAck, cfgOk, cfgLocked, accessViolation} == 4'b0, "R7 R9 reset outputs",
          256'({cfgAck, cfgOk, cfgLocked, accessViolation}), 256'(0));
    checkFlags("R6 R4 R5 reset flags");
    readReg(2'd1, v); check(v == 256'(IDV), "R2 id read", v, 256'(IDV));
    readReg(2'd0, v); check(v == '0, "R2 blank key", v, '0);
    readReg(2'd2, v); check(v == '0, "R2 blank cntl", v, '0);
    readReg(2'd3, v); check(v == '0, "R2 none select", v, '0);

    // Key write, read-back only after reset
    k1 = randWide();
    writeReg(2'd0, k1);
    readReg(2'd0, v); check(v == '0, "R11 key before reset", v, '0);
    doReset();
    readReg(2'd0, v); check(v == holdKeyM, "R1 key readback", v, holdKeyM);

    // One-way accumulation
    k2 = randWide();
    writeReg(2'd0, k2);
    doReset();
    readReg(2'd0, v); check(v == (k1 | k2), "R3 key OR", v, k1 | k2);
    writeReg(2'd0, '0);
    doReset();
    readReg(2'd0, v); check(v == (k1 | k2), "R3 zero write", v, k1 | k2);

    // Identifier is read-only
    writeReg(2'd1, randWide());
    doReset();
    readReg(2'd1, v); check(v == 256'(IDV), "R2 id write ignored", v, 256'(IDV));

    // Reserved control bits
    writeReg(2'd2, 256'($urandom & ~LIVE));
    doReset();
    readReg(2'd2, v); check(v == '0, "R8 reserved read zero", v, '0);
    checkFlags("R8 reserved no effect");

    // Open configuration, random patterns
    for (int i = 0; i < 30; i++)
      cfgTry($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 7) == 0), "R6 R10 open cfg");

    // Lock-after-config bit
    writeReg(2'd2, 256'(32'h0001_0000 | ($urandom & ~LIVE)));
    cfgTry(1'b0, 1'b0, 1'b0, "R11 lock not yet active");
    doReset();
    readReg(2'd2, v); check(v == 256'(32'h0001_0000), "R1 R8 cntl readback", v, 256'(32'h0001_0000));
    for (int i = 0; i < 40; i++)
      cfgTry($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 5) == 0), "R7 random lock");
    cfgTry(1'b0, 1'b1, 1'b0, "R7 lock set");
    cfgTry(1'b1, 1'b1, 1'b0, "R7 locked reject");
    cfgTry(1'b1, 1'b1, 1'b1, "R7 clear with request");
    cfgTry(1'b0, 1'b0, 1'b0, "R7 after clear");
    doReset();
    check(cfgLocked == 1'b0, "R7 reset unlocks", 256'(cfgLocked), 256'(0));

    // Key-only configuration
    writeReg(2'd2, 256'(32'h0002_0000));
    checkFlags("R11 key-only pending");
    doReset();
    checkFlags("R6 key-only flag");
    cfgTry(1'b0, 1'b1, 1'b0, "R6 plain rejected");
    cfgTry(1'b1, 1'b0, 1'b0, "R6 alt key rejected");
    cfgTry(1'b1, 1'b1, 1'b1, "R6 fuse key accepted");
    for (int i = 0; i < 40; i++)
      cfgTry($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 3) == 0), "R6 R7 random key-only");

    // Key protection through its second copy
    writeReg(2'd2, 256'(32'h0000_4000));
    doReset();
    checkFlags("R5 key blocked flag");
    check(accessViolation == 1'b0, "R9 clear after reset", 256'(accessViolation), 256'(0));
    readReg(2'd0, v); check(v == '0, "R5 key read zero", v, '0);
    check(accessViolation == 1'b1, "R9 blocked read flag", 256'(accessViolation), 256'(1));
    readReg(2'd1, v); check(v == 256'(IDV), "R2 id still readable", v, 256'(IDV));
    check(accessViolation == 1'b1, "R9 sticky", 256'(accessViolation), 256'(1));
    readReg(2'd2, v); check(v == 256'(32'h0003_4000), "R4 cntl open", v, 256'(32'h0003_4000));
    doReset();
    check(accessViolation == 1'b0, "R9 reset clears", 256'(accessViolation), 256'(0));
    writeReg(2'd0, randWide());
    check(accessViolation == 1'b1, "R9 R5 blocked key write", 256'(accessViolation), 256'(1));

    // Control protection through its second copy
    writeReg(2'd2, 256'(32'h0000_1000));
    doReset();
    checkFlags("R4 cntl blocked flag");
    readReg(2'd2, v); check(v == '0, "R4 cntl read zero", v, '0);
    check(accessViolation == 1'b1, "R9 R4 blocked cntl read", 256'(accessViolation), 256'(1));
    doReset();
    writeReg(2'd2, 256'(32'h0000_0400));
    check(accessViolation == 1'b1, "R9 R4 blocked cntl write", 256'(accessViolation), 256'(1));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule